// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block keeps wall-clock time and calendar date as packed BCD fields: seconds, minutes, hours (24-hour), day of week, date, month and a four-digit year. Each pulse on a one-second enable input advances the time by one second. Carries ripple from seconds through minutes, hours, date, month and year within the same clock edge. The block applies month lengths, the Gregorian leap-year rule and the century exceptions on its own. The day-of-week counter advances at every midnight and does not depend on the date.

A host sets the time by placing a complete base time on the parallel load port and pulsing the load strobe. The loaded value replaces every counter at once. A hold input freezes the visible outputs so that the host can read a consistent set of fields. Timekeeping continues underneath while hold is high. When hold is released, the outputs follow the live time again.

Top module: `cal_bcd_clock`

## Requirements
- R1: After a synchronous reset the outputs read 00:00:00, day of week 1, date 01, month 01, year 2000 (all BCD).
- R2: A tick advances the seconds by one in BCD. A digit at 9 becomes 0 and carries into the next digit. Seconds 59 become 00 and advance the minutes. Minutes 59 become 00 and advance the hours.
- R3: Hours count 00 to 23 in BCD. Hours 23 become 00 and advance both the date and the day of week.
- R4: The day of week, a BCD digit from 1 to 7, goes from 7 back to 1 at each midnight carry, whatever the date.
- R5: Months 04, 06, 09 and 11 end at date 30. February follows R6. All other months end at 31. After the last date the date becomes 01 and the month advances. Month 12 becomes 01 and advances the year.
- R6: February ends at 29 when the year is divisible by 4, except a year ending in 00 whose century digits are not divisible by 4. Otherwise it ends at 28.
- R7: The year counts in four BCD digits, and 9999 rolls over to 0000.
- R8: A load pulse replaces all fields with the load port values. The value shows on the outputs after the same edge when hold is low. Load wins over a tick in the same cycle, which is then lost.
- R9: With neither tick nor load, the time does not change.
- R10: While hold is high the outputs keep their value at every edge, and ticks and loads still act on the live time. At the first edge where hold is low, the outputs show the live time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-second advance enable, one cycle wide |
| hold | input | 1 | Freeze outputs while time keeps running |
| load | input | 1 | Load strobe for the base time |
| ld_sec | input | 8 | Base-time seconds, BCD |
| ld_min | input | 8 | Base-time minutes, BCD |
| ld_hour | input | 8 | Base-time hours, BCD 00-23 |
| ld_dow | input | 4 | Base-time day of week, 1-7 |
| ld_date | input | 8 | Base-time date, BCD |
| ld_month | input | 8 | Base-time month, BCD |
| ld_year | input | 16 | Base-time year, four BCD digits |
| t_sec | output | 8 | Seconds, BCD |
| t_min | output | 8 | Minutes, BCD |
| t_hour | output | 8 | Hours, BCD |
| t_dow | output | 4 | Day of week |
| t_date | output | 8 | Date, BCD |
| t_month | output | 8 | Month, BCD |
| t_year | output | 16 | Year, BCD |

## Verification
Every result is due one edge after the stimulus. A tick, a load or a hold release sampled at a rising edge appears on the outputs right after that edge, even when the carry runs from seconds through to the year. The bench drives inputs and compares all outputs at the falling edge, once for every rising edge. Its model therefore advances exactly once per edge between drive and compare. During hold it compares against the frozen value, and at release it compares against the live time, which includes the ticks that arrived during hold.

// File: rtl/calbcd_pkg.sv
`timescale 1ns/1ps
package calbcd_pkg;

    localparam int BCD_DIG_W = 4;
    localparam int FIELD_W   = 2 * BCD_DIG_W;
    localparam int YEAR_DIGS = 4;
    localparam int YEAR_W    = YEAR_DIGS * BCD_DIG_W;

    typedef struct packed {
        logic [YEAR_W-1:0]    year;
        logic [FIELD_W-1:0]   month;
        logic [FIELD_W-1:0]   date;
        logic [BCD_DIG_W-1:0] dow;
        logic [FIELD_W-1:0]   hour;
        logic [FIELD_W-1:0]   min;
        logic [FIELD_W-1:0]   sec;
    } cal_time_t;

    localparam cal_time_t CAL_RESET = '{
        year: 16'h2000, month: 8'h01, date: 8'h01, dow: 4'h1,
        hour: 8'h00, min: 8'h00, sec: 8'h00
    };

    // Two BCD digits (tens, ones) divisible by 4: (10t + o) mod 4 == (2t + o) mod 4
    function automatic logic bcd_pair_div4(input logic [FIELD_W-1:0] v);
        logic [5:0] s;
        s = {1'b0, v[7:4], 1'b0} + {2'b00, v[3:0]};
        return (s[1:0] == 2'b00);
    endfunction

    // Gregorian rule on a four-digit BCD year
    function automatic logic year_is_leap(input logic [YEAR_W-1:0] y);
        if (y[7:0] == 8'h00)
            return bcd_pair_div4(y[15:8]);
        return bcd_pair_div4(y[7:0]);
    endfunction

    function automatic logic [FIELD_W-1:0] month_last(input logic [FIELD_W-1:0] m,
                                                      input logic leap);
        case (m)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/cal_bcd_field.sv
`timescale 1ns/1ps
module cal_bcd_field #(
    parameter int            DIGITS = 2,
    parameter int            W      = 4 * DIGITS,
    parameter logic [W-1:0]  FIRST  = '0,
    parameter logic [W-1:0]  RSTV   = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic         load,
    input  logic [W-1:0] ld_val,
    input  logic [W-1:0] last_val,
    output logic [W-1:0] val_q,
    output logic [W-1:0] val_d,
    output logic         wrap
);

    logic [W-1:0]      inc;
    logic [DIGITS-1:0] cin;

    generate
        for (genvar g = 0; g < DIGITS; g++) begin : g_dig
            if (g == 0) begin : g_lsd
                assign cin[g] = 1'b1;
            end else begin : g_upper
                assign cin[g] = cin[g-1] && (val_q[4*(g-1) +: 4] == 4'd9);
            end
            assign inc[4*g +: 4] = !cin[g]                    ? val_q[4*g +: 4] :
                                   (val_q[4*g +: 4] == 4'd9)  ? 4'd0 :
                                   val_q[4*g +: 4] + 4'd1;
        end
    endgenerate

    always_comb begin
        wrap = step && !load && (val_q == last_val);
        if (load)
            val_d = ld_val;
        else if (step)
            val_d = (val_q == last_val) ? FIRST : inc;
        else
            val_d = val_q;
    end

    always_ff @(posedge clk) begin
        if (rst) val_q <= RSTV;
        else     val_q <= val_d;
    end

    // R5: a field that starts within its range stays within it after a step
    a_r5_within_last: assert property (@(posedge clk) disable iff (rst)
        (step && !load && val_q <= last_val && val_q >= FIRST) |=> (val_q <= last_val));

    // R9: no step and no load keeps the field
    a_r9_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (!step && !load) |=> $stable(val_q));

    // R2: a wrap returns the field to its first value
    a_r2_wrap_first: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (val_q == FIRST));

endmodule

// File: rtl/cal_month_len.sv
`timescale 1ns/1ps
module cal_month_len
    import calbcd_pkg::*;
(
    input  logic [YEAR_W-1:0]  year,
    input  logic [FIELD_W-1:0] month,
    output logic [FIELD_W-1:0] last_date,
    output logic               leap
);

    always_comb begin
        leap      = year_is_leap(year);
        last_date = month_last(month, leap);
    end

    // R6: February length agrees with the leap flag
    always_comb begin
        if (month == 8'h02)
            a_r6_feb_len: assert (last_date == (leap ? 8'h29 : 8'h28));
    end

endmodule

// File: rtl/cal_bcd_clock.sv
`timescale 1ns/1ps
module cal_bcd_clock
    import calbcd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 hold,
    input  logic                 load,
    input  logic [FIELD_W-1:0]   ld_sec,
    input  logic [FIELD_W-1:0]   ld_min,
    input  logic [FIELD_W-1:0]   ld_hour,
    input  logic [BCD_DIG_W-1:0] ld_dow,
    input  logic [FIELD_W-1:0]   ld_date,
    input  logic [FIELD_W-1:0]   ld_month,
    input  logic [YEAR_W-1:0]    ld_year,
    output logic [FIELD_W-1:0]   t_sec,
    output logic [FIELD_W-1:0]   t_min,
    output logic [FIELD_W-1:0]   t_hour,
    output logic [BCD_DIG_W-1:0] t_dow,
    output logic [FIELD_W-1:0]   t_date,
    output logic [FIELD_W-1:0]   t_month,
    output logic [YEAR_W-1:0]    t_year
);

    cal_time_t live_q, live_d, shown_q;
    logic      sec_wrap, min_wrap, hour_wrap, dow_wrap, date_wrap, month_wrap, year_wrap;
    logic [FIELD_W-1:0] date_last;
    logic               leap_now;

    cal_month_len u_mlen (
        .year(live_q.year), .month(live_q.month),
        .last_date(date_last), .leap(leap_now)
    );

    cal_bcd_field #(.DIGITS(2), .FIRST(8'h00), .RSTV(CAL_RESET.sec)) u_sec (
        .clk(clk), .rst(rst), .step(tick), .load(load), .ld_val(ld_sec),
        .last_val(8'h59), .val_q(live_q.sec), .val_d(live_d.sec), .wrap(sec_wrap));

    cal_bcd_field #(.DIGITS(2), .FIRST(8'h00), .RSTV(CAL_RESET.min)) u_min (
        .clk(clk), .rst(rst), .step(sec_wrap), .load(load), .ld_val(ld_min),
        .last_val(8'h59), .val_q(live_q.min), .val_d(live_d.min), .wrap(min_wrap));

    cal_bcd_field #(.DIGITS(2), .FIRST(8'h00), .RSTV(CAL_RESET.hour)) u_hour (
        .clk(clk), .rst(rst), .step(min_wrap), .load(load), .ld_val(ld_hour),
        .last_val(8'h23), .val_q(live_q.hour), .val_d(live_d.hour), .wrap(hour_wrap));

    cal_bcd_field #(.DIGITS(1), .FIRST(4'h1), .RSTV(CAL_RESET.dow)) u_dow (
        .clk(clk), .rst(rst), .step(hour_wrap), .load(load), .ld_val(ld_dow),
        .last_val(4'h7), .val_q(live_q.dow), .val_d(live_d.dow), .wrap(dow_wrap));

    cal_bcd_field #(.DIGITS(2), .FIRST(8'h01), .RSTV(CAL_RESET.date)) u_date (
        .clk(clk), .rst(rst), .step(hour_wrap), .load(load), .ld_val(ld_date),
        .last_val(date_last), .val_q(live_q.date), .val_d(live_d.date), .wrap(date_wrap));

    cal_bcd_field #(.DIGITS(2), .FIRST(8'h01), .RSTV(CAL_RESET.month)) u_month (
        .clk(clk), .rst(rst), .step(date_wrap), .load(load), .ld_val(ld_month),
        .last_val(8'h12), .val_q(live_q.month), .val_d(live_d.month), .wrap(month_wrap));

    cal_bcd_field #(.DIGITS(YEAR_DIGS), .FIRST(16'h0000), .RSTV(CAL_RESET.year)) u_year (
        .clk(clk), .rst(rst), .step(month_wrap), .load(load), .ld_val(ld_year),
        .last_val(16'h9999), .val_q(live_q.year), .val_d(live_d.year), .wrap(year_wrap));

    // Visible copy: follows the next live value unless held
    always_ff @(posedge clk) begin
        if (rst)       shown_q <= CAL_RESET;
        else if (!hold) shown_q <= live_d;
    end

    assign t_sec   = shown_q.sec;
    assign t_min   = shown_q.min;
    assign t_hour  = shown_q.hour;
    assign t_dow   = shown_q.dow;
    assign t_date  = shown_q.date;
    assign t_month = shown_q.month;
    assign t_year  = shown_q.year;

    // R10: held outputs do not move
    a_r10_hold_freeze: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(shown_q));

    // R8: load takes effect on the outputs after one edge when not held
    a_r8_load_visible: assert property (@(posedge clk) disable iff (rst)
        (load && !hold) |=> (t_sec == $past(ld_sec) && t_min == $past(ld_min) &&
                             t_hour == $past(ld_hour) && t_dow == $past(ld_dow) &&
                             t_date == $past(ld_date) && t_month == $past(ld_month) &&
                             t_year == $past(ld_year)));

    // R4: day of week restarts at 1 after 7
    a_r4_dow_restart: assert property (@(posedge clk) disable iff (rst)
        dow_wrap |=> (live_q.dow == 4'h1));

    // R7: year rollover lands on 0000 together with January
    a_r7_year_rollover: assert property (@(posedge clk) disable iff (rst)
        year_wrap |=> (live_q.year == 16'h0000 && live_q.month == 8'h01));

    // R6: on a leap year, Feb 28 at midnight moves to Feb 29
    a_r6_leap_feb: assert property (@(posedge clk) disable iff (rst)
        (hour_wrap && leap_now && live_q.month == 8'h02 && live_q.date == 8'h28)
        |=> (live_q.date == 8'h29));

endmodule

// File: tb/sim_cal_bcd_clock.sv
`timescale 1ns/1ps
module sim_cal_bcd_clock;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0, hold = 1'b0, load = 1'b0;
    logic [7:0]  ld_sec = '0, ld_min = '0, ld_hour = '0, ld_date = '0, ld_month = '0;
    logic [3:0]  ld_dow = '0;
    logic [15:0] ld_year = '0;
    logic [7:0]  t_sec, t_min, t_hour, t_date, t_month;
    logic [3:0]  t_dow;
    logic [15:0] t_year;

    always #2.5 clk = ~clk;

    cal_bcd_clock u0 (
        .clk(clk), .rst(rst), .tick(tick), .hold(hold), .load(load),
        .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour), .ld_dow(ld_dow),
        .ld_date(ld_date), .ld_month(ld_month), .ld_year(ld_year),
        .t_sec(t_sec), .t_min(t_min), .t_hour(t_hour), .t_dow(t_dow),
        .t_date(t_date), .t_month(t_month), .t_year(t_year));

    int n_cmp = 0, n_bad = 0;
    // live model, shown model, load values (plain integers)
    int m_s, m_mi, m_h, m_w, m_d, m_mo, m_y;
    int o_s, o_mi, o_h, o_w, o_d, o_mo, o_y;
    int l_s, l_mi, l_h, l_w, l_d, l_mo, l_y;

    function automatic logic [7:0] b2(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction
    function automatic logic [15:0] b4(input int v);
        return {4'(v / 1000), 4'((v / 100) % 10), 4'((v / 10) % 10), 4'(v % 10)};
    endfunction
    function automatic bit leap_y(input int y);
        return ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
    endfunction
    function automatic int mdays(input int mo, input int y);
        if (mo == 2) return leap_y(y) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic model_adv();
        m_s++;
        if (m_s == 60) begin
            m_s = 0; m_mi++;
            if (m_mi == 60) begin
                m_mi = 0; m_h++;
                if (m_h == 24) begin
                    m_h = 0;
                    m_w = (m_w == 7) ? 1 : m_w + 1;
                    m_d++;
                    if (m_d > mdays(m_mo, m_y)) begin
                        m_d = 1; m_mo++;
                        if (m_mo == 13) begin
                            m_mo = 1; m_y = (m_y + 1) % 10000;
                        end
                    end
                end
            end
        end
    endtask

    task automatic check(input string tag);
        logic [59:0] exp_v, act_v;
        exp_v = {b4(o_y), b2(o_mo), b2(o_d), 4'(o_w), b2(o_h), b2(o_mi), b2(o_s)};
        act_v = {t_year, t_month, t_date, t_dow, t_hour, t_min, t_sec};
        n_cmp++;
        if (act_v !== exp_v) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h (year,mon,date,dow,hour,min,sec)",
                     tag, act_v, exp_v);
        end
    endtask

    task automatic set_ld(input int y, mo, d, w, h, mi, s);
        l_y = y; l_mo = mo; l_d = d; l_w = w; l_h = h; l_mi = mi; l_s = s;
    endtask

    // one clock: drive after falling edge, model the rising edge, compare at next falling edge
    task automatic cyc(input bit tk, input bit ld, input bit hd, input string tag);
        tick = tk; load = ld; hold = hd;
        ld_sec = b2(l_s); ld_min = b2(l_mi); ld_hour = b2(l_h); ld_dow = 4'(l_w);
        ld_date = b2(l_d); ld_month = b2(l_mo); ld_year = b4(l_y);
        @(posedge clk);
        if (ld) begin
            m_s = l_s; m_mi = l_mi; m_h = l_h; m_w = l_w; m_d = l_d; m_mo = l_mo; m_y = l_y;
        end else if (tk) begin
            model_adv();
        end
        if (!hd) begin
            o_s = m_s; o_mi = m_mi; o_h = m_h; o_w = m_w; o_d = m_d; o_mo = m_mo; o_y = m_y;
        end
        @(negedge clk);
        check(tag);
    endtask

    // load a time just before midnight, then one tick
    task automatic edge_case(input int y, mo, d, w, input string tag);
        set_ld(y, mo, d, w, 23, 59, 59);
        cyc(0, 1, 0, "R8");
        cyc(1, 0, 0, tag);
    endtask

    initial begin
        #500us;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240229));
        m_s = 0; m_mi = 0; m_h = 0; m_w = 1; m_d = 1; m_mo = 1; m_y = 2000;
        o_s = 0; o_mi = 0; o_h = 0; o_w = 1; o_d = 1; o_mo = 1; o_y = 2000;
        set_ld(0, 1, 1, 1, 0, 0, 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1");

        // R9: idle cycles
        repeat (3) cyc(0, 0, 0, "R9");
        // R8: load a base time
        set_ld(2024, 2, 28, 3, 12, 34, 56);
        cyc(0, 1, 0, "R8");
        // R2: seconds carry into minutes
        repeat (5) cyc(1, 0, 0, "R2");
        set_ld(2023, 5, 5, 2, 9, 59, 59);
        cyc(0, 1, 0, "R8");
        cyc(1, 0, 0, "R3");
        set_ld(2023, 5, 5, 2, 22, 59, 59);
        cyc(0, 1, 0, "R8");
        cyc(1, 0, 0, "R3");
        // R6: leap-year corners
        edge_case(2024, 2, 28, 7, "R6");
        cyc(0, 0, 0, "R4");
        edge_case(2024, 2, 29, 4, "R6");
        edge_case(1900, 2, 28, 1, "R6");
        edge_case(2000, 2, 28, 1, "R6");
        edge_case(2100, 2, 28, 1, "R6");
        edge_case(2400, 2, 28, 1, "R6");
        edge_case(2023, 2, 28, 1, "R6");
        // R5: month lengths and year carry
        edge_case(2023, 4, 30, 5, "R5");
        edge_case(2023, 11, 30, 5, "R5");
        edge_case(2023, 1, 31, 5, "R5");
        edge_case(2023, 8, 30, 5, "R5");
        edge_case(2023, 12, 31, 6, "R5");
        // R7: year carries and rollover
        edge_case(999, 12, 31, 2, "R7");
        edge_case(9999, 12, 31, 7, "R7");
        // R8: load beats a simultaneous tick
        set_ld(2010, 10, 10, 3, 10, 10, 10);
        cyc(1, 1, 0, "R8");
        // R10: hold freezes outputs, time runs, load stays hidden
        repeat (4) cyc(1, 0, 1, "R10");
        set_ld(2031, 3, 31, 2, 23, 59, 58);
        cyc(0, 1, 1, "R10");
        cyc(1, 0, 1, "R10");
        cyc(0, 0, 0, "R10");
        cyc(1, 0, 0, "R10");

        // random mix with rollover-biased loads
        begin
            bit hd = 1'b0;
            for (int i = 0; i < 4000; i++) begin
                bit tk, ld;
                tk = ($urandom % 4) != 0;
                ld = ($urandom % 40) == 0;
                if (($urandom % 16) == 0) hd = ~hd;
                if (ld) begin
                    int y, mo, d;
                    case ($urandom % 6)
                        0: y = 1900; 1: y = 2000; 2: y = 2100;
                        3: y = 9999; 4: y = 2024; default: y = $urandom % 10000;
                    endcase
                    mo = ($urandom % 3 == 0) ? 2 : 1 + ($urandom % 12);
                    d  = mdays(mo, y) - ($urandom % 2);
                    set_ld(y, mo, d, 1 + ($urandom % 7),
                           ($urandom % 2) ? 23 : $urandom % 24,
                           ($urandom % 2) ? 59 : $urandom % 60,
                           55 + ($urandom % 5));
                end
                cyc(tk, ld, hd, hd ? "R10" : "R2");
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule